// File: doc/BRIEF.md
# Memory access latency estimator

This block prices one memory access in processor clock cycles, so that a timing model of a pipelined core can add the result to its running cycle count. Each request gives the following:

- the address, the access size, the direction and a sequential flag;
- the kind of access (instruction fetch, data, or DMA);
- which of two core flavours issues it. One is a five-stage core with caches and a tightly coupled instruction memory. The other is a three-stage core without them.

A hit flag from an external tag directory tells the block whether a cached access would hit. The block does not store tags and does not arbitrate any bus.

From these inputs the block finds the access region: tightly coupled memory, the cached main-memory window, or the plain bus. It then applies the cost formula for that region. The formula depends on the bus width units of the core, the access size, hit or miss, direction and sequentiality. A read miss also pays for a full line fill.

Alongside the memory cost, the block folds in an ALU cycle count and a fetch cycle count:
- The execute figure is the larger of ALU and memory cycles on the five-stage core, where the two stages overlap. On the three-stage core it is their sum.
- The total figure is the larger of execute and fetch cycles when timing modelling is on, and the execute figure alone when it is off.

All results are registered and appear one cycle after the request.

Top module: `mem_lat_est`

## Requirements
- R1: `resp_valid` is 1 exactly in the cycle after a cycle with `req_valid` = 1, and 0 otherwise. `cycles`, `exec_cycles` and `total_cycles` load only on a request and otherwise keep their value. After reset all outputs are 0.
- R2: The wide-bus unit is 2 cycles when `cpu_sel` = 1 (five-stage core) and 1 cycle when `cpu_sel` = 0. The narrow-bus unit is twice the wide-bus unit for `size` = 2 (32-bit) or 3 (treated as 32-bit), and equal to it for `size` = 0 (8-bit) or 1 (16-bit). A sequential access on the plain-bus region costs exactly the narrow-bus unit.
- R3: With `cpu_sel` = 1, an instruction fetch (`acc_type` = 0) whose size-aligned address is below 0x02000000 costs 1 cycle, whatever the other inputs.
- R4: With `cpu_sel` = 1, a code or data access (`acc_type` 0 or 1) whose aligned address has bits 27:24 equal to 2 takes the cached path. There a hit (`hit` = 1) costs 1 cycle.
- R5: A miss on the cached path costs a base amount:
  - the narrow-bus unit for a sequential data access (`seq` = 1, `acc_type` = 1);
  - 5 narrow-bus units for any other read (`is_write` = 0);
  - 2 narrow-bus units for any other write.
- R6: A read miss on the cached path adds a line-fill surcharge of 16 wide-bus units to the R5 base.
- R7: Every other access costs one narrow-bus unit, plus a non-sequential penalty when `seq` = 0. The penalty is 6 cycles with `cpu_sel` = 1 and 1 cycle with `cpu_sel` = 0. This covers DMA (`acc_type` 2 or 3), all accesses of the three-stage core, and five-stage accesses outside both windows. `hit` has no effect on these accesses.
- R8: `exec_cycles` is max(`alu_cyc`, memory cost) with `cpu_sel` = 1 and `alu_cyc` + memory cost with `cpu_sel` = 0.
- R9: `total_cycles` is max(execute figure, `fetch_cyc`) when `timing_en` = 1, and equals the execute figure when `timing_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| addr | input | 32 | Byte address of the access |
| size | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit |
| is_write | input | 1 | 1 = write, 0 = read |
| seq | input | 1 | Access follows the previous one sequentially |
| acc_type | input | 2 | 0 = instruction fetch, 1 = data, 2 or 3 = DMA |
| cpu_sel | input | 1 | 1 = five-stage cached core, 0 = three-stage core |
| hit | input | 1 | Tag directory reports a hit for this address |
| timing_en | input | 1 | Fetch overlap modelling enabled |
| alu_cyc | input | 8 | ALU stage cycles of the instruction |
| fetch_cyc | input | 8 | Fetch stage cycles of the instruction |
| resp_valid | output | 1 | Results below belong to last cycle's request |
| cycles | output | 8 | Memory access cost in cycles |
| exec_cycles | output | 9 | ALU and memory stages combined |
| total_cycles | output | 9 | Execute and fetch stages combined |

## Verification
Every result is due at the first rising edge after the cycle in which the request was presented. The memory cost, the execute figure and the total figure all appear together, and `resp_valid` rises on that same edge. The bench drives each request on the falling edge and samples one time unit after the next rising edge, so no check races the register update. Idle cycles with changed inputs are checked after one further edge to confirm that the outputs held. The sweep covers both cores, every access kind, size, direction, sequential flag and hit value, over addresses on both sides of each region boundary.

// File: rtl/lat_pkg.sv
package lat_pkg;

  // access kind encoding on acc_type
  typedef enum logic [1:0] {
    ACC_CODE    = 2'd0,
    ACC_DATA    = 2'd1,
    ACC_DMA     = 2'd2,
    ACC_DMA_ALT = 2'd3
  } acc_e;

  // region chosen for pricing
  typedef enum logic [1:0] {
    PATH_TCM   = 2'd0,
    PATH_CACHE = 2'd1,
    PATH_BUS   = 2'd2
  } path_e;

  // cycles of one beat on the wide bus
  function automatic int unsigned wide_unit(input logic cpu5);
    return cpu5 ? 32'd2 : 32'd1;
  endfunction

  // cycles of one access on the narrow bus, doubled for words
  function automatic int unsigned narrow_unit(input logic cpu5, input logic [1:0] sz);
    return wide_unit(cpu5) * ((sz >= 2'd2) ? 32'd2 : 32'd1);
  endfunction

  // bits of the low address byte lane kept after size alignment
  function automatic logic [1:0] lane_keep(input logic [1:0] sz);
    case (sz)
      2'd0:    return 2'b11;
      2'd1:    return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  function automatic int unsigned larger(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lat_region_dec.sv
module lat_region_dec
  import lat_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] ITCM_LIMIT  = 32'h0200_0000,
  parameter logic [AW-1:0] CACHE_MASK  = 32'h0F00_0000,
  parameter logic [AW-1:0] CACHE_MATCH = 32'h0200_0000
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic [1:0]    acc_type,
  input  logic          cpu5,
  output path_e         path,
  output logic          in_itcm,
  output logic          in_cache
);

  logic [AW-1:0] addr_al;
  logic          is_code;
  logic          is_dma;

  assign addr_al = {addr[AW-1:2], addr[1:0] & lane_keep(size)};
  assign is_code = (acc_type == ACC_CODE);
  assign is_dma  = acc_type[1];

  assign in_itcm  = cpu5 && is_code && (addr_al < ITCM_LIMIT);
  assign in_cache = cpu5 && !is_dma && !in_itcm &&
                    ((addr_al & CACHE_MASK) == CACHE_MATCH);

  always_comb begin
    if (in_itcm)       path = PATH_TCM;
    else if (in_cache) path = PATH_CACHE;
    else               path = PATH_BUS;
  end

endmodule

// File: rtl/lat_cost_calc.sv
module lat_cost_calc
  import lat_pkg::*;
#(
  parameter int CW             = 8,
  parameter int FILL_BEATS     = 8,
  parameter int MISS_RD_MULT   = 5,
  parameter int MISS_WR_MULT   = 2,
  parameter int NS_PEN_DEEP    = 6,
  parameter int NS_PEN_SHALLOW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  path_e         path,
  input  logic          cpu5,
  input  logic [1:0]    size,
  input  logic          is_write,
  input  logic          seq,
  input  logic          is_data,
  input  logic          hit,
  output logic [CW-1:0] cost,
  output logic          line_fill,
  output logic          ns_penalty
);

  int unsigned u_wide;
  int unsigned u_narrow;
  int unsigned miss_base;
  int unsigned raw;

  assign line_fill  = (path == PATH_CACHE) && !hit && !is_write;
  assign ns_penalty = (path == PATH_BUS) && !seq;

  always_comb begin
    u_wide   = wide_unit(cpu5);
    u_narrow = narrow_unit(cpu5, size);
    if (seq && is_data)  miss_base = u_narrow;
    else if (!is_write)  miss_base = u_narrow * MISS_RD_MULT;
    else                 miss_base = u_narrow * MISS_WR_MULT;
    case (path)
      PATH_TCM:   raw = 32'd1;
      PATH_CACHE: begin
        if (hit) raw = 32'd1;
        else     raw = miss_base + (line_fill ? FILL_BEATS * 2 * u_wide : 32'd0);
      end
      default: begin
        raw = u_narrow;
        if (ns_penalty) raw = raw + (cpu5 ? NS_PEN_DEEP : NS_PEN_SHALLOW);
      end
    endcase
    cost = CW'(raw);
  end

  // R4: a cached hit is priced as a single cycle
  a_r4_hit_single: assert property (@(posedge clk) disable iff (!rst_n)
    (path == PATH_CACHE && hit) |-> (cost == CW'(1)));

  // R6: a line fill always costs more than the fill beats alone
  a_r6_fill_floor: assert property (@(posedge clk) disable iff (!rst_n)
    line_fill |-> (32'(cost) > 32'(FILL_BEATS * 2)));

  // R7: a non-sequential bus access exceeds the narrow unit
  a_r7_penalty_added: assert property (@(posedge clk) disable iff (!rst_n)
    ns_penalty |-> (32'(cost) > narrow_unit(cpu5, size)));

  // R7: a sequential bus access is never cheaper than one cycle
  a_r7_bus_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (path == PATH_BUS) |-> (cost != '0));

endmodule

// File: rtl/lat_stage_comb.sv
module lat_stage_comb
  import lat_pkg::*;
#(
  parameter int CW = 8,
  localparam int XW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu5,
  input  logic          timing_en,
  input  logic [CW-1:0] mem_cyc,
  input  logic [CW-1:0] alu_cyc,
  input  logic [CW-1:0] fetch_cyc,
  output logic [XW-1:0] exec_cyc,
  output logic [XW-1:0] total_cyc
);

  always_comb begin
    if (cpu5) exec_cyc = XW'(larger(32'(alu_cyc), 32'(mem_cyc)));
    else      exec_cyc = XW'(alu_cyc) + XW'(mem_cyc);
    if (timing_en) total_cyc = XW'(larger(32'(exec_cyc), 32'(fetch_cyc)));
    else           total_cyc = exec_cyc;
  end

  // R8: the execute figure covers both of its stages
  a_r8_exec_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_cyc >= XW'(alu_cyc)) && (exec_cyc >= XW'(mem_cyc)));

  // R8: with overlap the figure equals one of the two stages
  a_r8_overlap_pick: assert property (@(posedge clk) disable iff (!rst_n)
    cpu5 |-> ((exec_cyc == XW'(alu_cyc)) || (exec_cyc == XW'(mem_cyc))));

  // R9: disabled modelling leaves the execute figure untouched
  a_r9_fetch_off: assert property (@(posedge clk) disable iff (!rst_n)
    !timing_en |-> (total_cyc == exec_cyc));

  // R9: the total never falls below the execute figure
  a_r9_total_floor: assert property (@(posedge clk) disable iff (!rst_n)
    total_cyc >= exec_cyc);

endmodule

// File: rtl/mem_lat_est.sv
module mem_lat_est
  import lat_pkg::*;
#(
  parameter int AW             = 32,
  parameter int CW             = 8,
  parameter int FILL_BEATS     = 8,
  parameter int MISS_RD_MULT   = 5,
  parameter int MISS_WR_MULT   = 2,
  parameter int NS_PEN_DEEP    = 6,
  parameter int NS_PEN_SHALLOW = 1,
  parameter logic [AW-1:0] ITCM_LIMIT  = 32'h0200_0000,
  parameter logic [AW-1:0] CACHE_MASK  = 32'h0F00_0000,
  parameter logic [AW-1:0] CACHE_MATCH = 32'h0200_0000,
  localparam int XW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic          is_write,
  input  logic          seq,
  input  logic [1:0]    acc_type,
  input  logic          cpu_sel,
  input  logic          hit,
  input  logic          timing_en,
  input  logic [CW-1:0] alu_cyc,
  input  logic [CW-1:0] fetch_cyc,
  output logic          resp_valid,
  output logic [CW-1:0] cycles,
  output logic [XW-1:0] exec_cycles,
  output logic [XW-1:0] total_cycles
);

  path_e         path_w;
  logic          itcm_w;
  logic          cache_w;
  logic          fill_w;
  logic          ns_pen_w;
  logic [CW-1:0] cost_w;
  logic [XW-1:0] exec_w;
  logic [XW-1:0] total_w;

  lat_region_dec #(
    .AW(AW), .ITCM_LIMIT(ITCM_LIMIT),
    .CACHE_MASK(CACHE_MASK), .CACHE_MATCH(CACHE_MATCH)
  ) u_region (
    .addr(addr), .size(size), .acc_type(acc_type), .cpu5(cpu_sel),
    .path(path_w), .in_itcm(itcm_w), .in_cache(cache_w)
  );

  lat_cost_calc #(
    .CW(CW), .FILL_BEATS(FILL_BEATS), .MISS_RD_MULT(MISS_RD_MULT),
    .MISS_WR_MULT(MISS_WR_MULT), .NS_PEN_DEEP(NS_PEN_DEEP),
    .NS_PEN_SHALLOW(NS_PEN_SHALLOW)
  ) u_cost (
    .clk(clk), .rst_n(rst_n), .path(path_w), .cpu5(cpu_sel), .size(size),
    .is_write(is_write), .seq(seq), .is_data(acc_type == ACC_DATA), .hit(hit),
    .cost(cost_w), .line_fill(fill_w), .ns_penalty(ns_pen_w)
  );

  lat_stage_comb #(.CW(CW)) u_stage (
    .clk(clk), .rst_n(rst_n), .cpu5(cpu_sel), .timing_en(timing_en),
    .mem_cyc(cost_w), .alu_cyc(alu_cyc), .fetch_cyc(fetch_cyc),
    .exec_cyc(exec_w), .total_cyc(total_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid   <= 1'b0;
      cycles       <= '0;
      exec_cycles  <= '0;
      total_cycles <= '0;
    end else begin
      resp_valid <= req_valid;
      if (req_valid) begin
        cycles       <= cost_w;
        exec_cycles  <= exec_w;
        total_cycles <= total_w;
      end
    end
  end

  // R1: a response follows every request one cycle later
  a_r1_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  // R1: no response appears without a request
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);

  // R1: results hold across idle cycles
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(cycles) && $stable(exec_cycles) && $stable(total_cycles)));

  // R3: tightly coupled fetches come back at one cycle
  a_r3_itcm_single: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && itcm_w) |=> (cycles == CW'(1)));

  // R4: the two windows never claim the same access
  a_r4_region_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(itcm_w && cache_w));

  // R6: the surcharged read miss is the dearest cached outcome
  a_r6_fill_result: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && fill_w) |=> (32'(cycles) >= 32'(FILL_BEATS * 2 + 1)));

  // R7: a sequential bus access is exactly one narrow unit
  a_r2_bus_seq_unit: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && path_w == PATH_BUS && !ns_pen_w) |=>
      (32'(cycles) == narrow_unit($past(cpu_sel), $past(size))));

endmodule

// File: tb/sim_mem_lat_est.sv
module sim_mem_lat_est;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0] size = '0;
  logic       is_write = 1'b0;
  logic       seq = 1'b0;
  logic [1:0] acc_type = '0;
  logic       cpu_sel = 1'b0;
  logic       hit = 1'b0;
  logic       timing_en = 1'b0;
  logic [7:0] alu_cyc = '0;
  logic [7:0] fetch_cyc = '0;
  logic       resp_valid;
  logic [7:0] cycles;
  logic [8:0] exec_cycles;
  logic [8:0] total_cycles;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mem_lat_est u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .addr(addr), .size(size),
    .is_write(is_write), .seq(seq), .acc_type(acc_type), .cpu_sel(cpu_sel),
    .hit(hit), .timing_en(timing_en), .alu_cyc(alu_cyc), .fetch_cyc(fetch_cyc),
    .resp_valid(resp_valid), .cycles(cycles), .exec_cycles(exec_cycles),
    .total_cycles(total_cycles)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // independent price model written from the requirements
  function automatic int model_cost(input bit deep, input int sz, input int kind,
                                    input bit wr, input bit sq, input bit ht,
                                    input int unsigned a, output string tag);
    int w, n, top;
    w   = deep ? 2 : 1;
    n   = (sz >= 2) ? 2 * w : w;
    top = int'(a >> 24);
    if (deep && kind == 0 && a < 32'h0200_0000) begin
      tag = "R3 tcm fetch";
      return 1;
    end
    if (deep && kind < 2 && (top % 16) == 2) begin
      if (ht) begin
        tag = "R4 cached hit";
        return 1;
      end
      if (wr) begin
        tag = "R5 write miss";
        return (sq && kind == 1) ? n : 2 * n;
      end
      tag = "R6 read miss fill";
      return ((sq && kind == 1) ? n : 5 * n) + 16 * w;
    end
    if (sq) begin
      tag = "R2 bus unit";
      return n;
    end
    tag = "R7 bus nonseq";
    return n + (deep ? 6 : 1);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    int last_cost, last_exec, last_total, idx;
    int unsigned addr_set [7];
    addr_set[0] = 32'h0000_1003;
    addr_set[1] = 32'h01FF_FFFE;
    addr_set[2] = 32'h0200_0001;
    addr_set[3] = 32'h0234_5678;
    addr_set[4] = 32'h1234_5671;
    addr_set[5] = 32'h0300_0000;
    addr_set[6] = 32'hF1FF_FFFF;
    last_cost = 0; last_exec = 0; last_total = 0; idx = 0;

    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset valid", int'(resp_valid), 0);
    chk("R1 reset cycles", int'(cycles), 0);
    chk("R1 reset exec", int'(exec_cycles), 0);
    chk("R1 reset total", int'(total_cycles), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int c = 0; c < 2; c++)
      for (int k = 0; k < 4; k++)
        for (int s = 0; s < 4; s++)
          for (int wv = 0; wv < 2; wv++)
            for (int q = 0; q < 2; q++)
              for (int h = 0; h < 2; h++)
                for (int ai = 0; ai < 7; ai++) begin
                  string tag;
                  int ec, ex, et, alu_v, fet_v;
                  bit ten;
                  alu_v = (idx * 37 + 3) % 256;
                  fet_v = (idx * 53 + 11) % 256;
                  ten   = ((idx % 2) ^ ((idx / 8) % 2)) != 0;
                  ec = model_cost(c != 0, s, k, wv != 0, q != 0, h != 0, addr_set[ai], tag);
                  ex = (c != 0) ? ((alu_v > ec) ? alu_v : ec) : alu_v + ec;
                  et = (ten && fet_v > ex) ? fet_v : ex;
                  @(negedge clk);
                  req_valid = 1'b1;
                  cpu_sel   = (c != 0);
                  acc_type  = 2'(k);
                  size      = 2'(s);
                  is_write  = (wv != 0);
                  seq       = (q != 0);
                  hit       = (h != 0);
                  addr      = addr_set[ai];
                  alu_cyc   = 8'(alu_v);
                  fetch_cyc = 8'(fet_v);
                  timing_en = ten;
                  @(posedge clk);
                  #1;
                  chk("R1 valid after request", int'(resp_valid), 1);
                  chk(tag, int'(cycles), ec);
                  chk("R8 exec combine", int'(exec_cycles), ex);
                  chk("R9 fetch combine", int'(total_cycles), et);
                  last_cost = ec; last_exec = ex; last_total = et;
                  idx++;
                  if (idx % 97 == 0) begin
                    // idle cycle with altered inputs: outputs must hold
                    @(negedge clk);
                    req_valid = 1'b0;
                    addr      = 32'h0234_0000;
                    cpu_sel   = ~cpu_sel;
                    hit       = ~hit;
                    alu_cyc   = 8'd200;
                    @(posedge clk);
                    #1;
                    chk("R1 idle valid", int'(resp_valid), 0);
                    chk("R1 idle hold cycles", int'(cycles), last_cost);
                    chk("R1 idle hold exec", int'(exec_cycles), last_exec);
                    chk("R1 idle hold total", int'(total_cycles), last_total);
                  end
                end

    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    #1;
    chk("R1 final idle valid", int'(resp_valid), 0);
    chk("R1 final hold cycles", int'(cycles), last_cost);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule